// File: doc/BRIEF.md
# Clock Divider with Deferred Ratio Update

This block turns a single fast PLL clock into a set of divided clock enables, one lane per downstream domain (core, bus, peripheral, memory and so on). Each lane emits a one-cycle enable pulse once every N cycles of the PLL clock. N comes from a 3-bit ratio code held in a control word. Software writes that word through a plain register write port. Writing a ratio does not retune the lanes at once. The new codes go into a shadow copy first. They reach the lanes either after that same write, when its immediate-update bit is set, or later, when the PLL is relocked with a new multiplier or is switched off.

Every change of ratio lands on a cycle in which all lanes end their period together. No lane ever produces a shortened or doubled period. A small sequencer owns the PLL enable. When the PLL is switched on or retuned, it counts a programmed settling time and then raises a stable flag. The block also holds a word-wide device divider setting that comes out of reset as 4.

Top module: `clkdiv_ctrl`

## Requirements
- R1: After reset every lane has ratio code 0, so every bit of `div_en` is 1 on every cycle. `pll_on`, `pll_stable` and `pll_mult` are 0, and `dev_div` is 4.
- R2: Lane i reads its code from bits [3i+2:3i] of the ratio word. Codes 0, 1, 2, 3, 4 and 5 give periods of 1, 2, 3, 4, 6 and 8 cycles. A lane pulses `div_en[i]` on the last cycle of each period.
- R3: Codes 6 and 7 behave as a period of 1.
- R4: A ratio write (`wr_sel`=0) with bit 31 set requests an update. The shadow codes take effect at the next common boundary.
- R5: A ratio write with bit 31 clear only changes the shadow codes. The lane periods stay as they were.
- R6: A PLL write (`wr_sel`=1) with bit 0 clear, made while the PLL is on, has two effects. `pll_stable` and `pll_on` are low on the next cycle, and an update of the shadow codes is requested.
- R7: A PLL write with bit 0 set, made while the PLL is on, and carrying a multiplier field (bits 31:16) different from the current one, requests an update and restarts the settling count.
- R8: The settling time T is bits 8:1 of the PLL word. After an enable or a retune write, `pll_stable` rises 16·T+1 cycles after the write edge. It is never high while `pll_on` is low.
- R9: Applied codes change only on a cycle in which every lane is on the last cycle of its period. All lanes then restart their count together.
- R10: A device-divider write (`wr_sel`=2) is taken only when all four `wr_be` bits are set. A partial write leaves `dev_div` unchanged.
- R11: Switching the PLL on from off starts the settling count but does not apply pending shadow codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PLL output clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 ratio word, 1 PLL word, 2 device divider |
| wr_be | input | 4 | Byte enables of the write |
| wr_data | input | 32 | Write data |
| div_en | output | 5 | Divided clock enables, one per lane |
| pll_on | output | 1 | PLL enable to the analog macro |
| pll_stable | output | 1 | Settling time has elapsed |
| pll_mult | output | 16 | Multiplier setting to the analog macro |
| dev_div | output | 32 | Device divider setting |

## Verification
Ratio writes arrive at awkward phases: mid-period, and back to back with an immediate write followed by a deferred one before the boundary. A design that applied codes on the write cycle would cut a pulse short. A design that latched the shadow at request time would apply stale codes. Deferred writes are followed first by a PLL power-up, which must leave them pending. They are then followed by a retune and by a switch-off, either of which must release them. A design that only reacted to disable would keep the old periods. The settling count is run with T=0 and is also cut short by a disable. Both expose an off-by-one error or a stable flag that outlives the enable. A partial-byte write to the device divider catches a design that takes it.

// File: rtl/cdu_pkg.sv
package cdu_pkg;
  localparam int CODE_W = 3;
  localparam int CNT_W  = 3;

  typedef logic [CODE_W-1:0] code_t;

  typedef enum logic [1:0] {
    SEL_RATIO = 2'd0,
    SEL_PLL   = 2'd1,
    SEL_DEV   = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  // last count value of a lane period (period minus one)
  function automatic logic [CNT_W-1:0] code_last(input code_t c);
    case (c)
      3'd1:    return 3'd1;
      3'd2:    return 3'd2;
      3'd3:    return 3'd3;
      3'd4:    return 3'd5;
      3'd5:    return 3'd7;
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/cdu_div_lane.sv
module cdu_div_lane
  import cdu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  code_t code,
  output logic  tick
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  assign last = code_last(code);
  assign tick = (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cdu_ratio_bank.sv
module cdu_ratio_bank
  import cdu_pkg::*;
#(
  parameter int N_OUT = 5,
  localparam int FIELD_W = N_OUT * CODE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_wr,
  input  logic [FIELD_W-1:0] ctl_codes,
  input  logic               ctl_now,
  input  logic               apply_evt,
  input  logic               boundary,
  output logic [FIELD_W-1:0] applied,
  output logic               req
);
  logic [FIELD_W-1:0] shadow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow  <= '0;
      applied <= '0;
      req     <= 1'b0;
    end else begin
      if (ctl_wr)
        shadow <= ctl_codes;
      if (req && boundary)
        applied <= shadow;
      req <= (req && !boundary) || (ctl_wr && ctl_now) || apply_evt;
    end
  end
endmodule

// File: rtl/cdu_lock_seq.sv
module cdu_lock_seq #(
  parameter int STAB_W     = 8,
  parameter int LOCK_SHIFT = 4,
  parameter int MULT_W     = 16,
  localparam int LCNT_W    = STAB_W + LOCK_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pll_wr,
  input  logic              wr_on,
  input  logic [STAB_W-1:0] wr_stab,
  input  logic [MULT_W-1:0] wr_mult,
  output logic              on,
  output logic              stable,
  output logic [MULT_W-1:0] mult,
  output logic              apply_evt
);
  logic [STAB_W-1:0] stab;
  logic [LCNT_W-1:0] lcnt;
  logic [LCNT_W-1:0] target;
  logic              locking;
  logic              restart;
  logic              mult_new;

  assign target    = {stab, {LOCK_SHIFT{1'b0}}};
  assign mult_new  = (wr_mult != mult);
  assign apply_evt = pll_wr && on && (!wr_on || mult_new);
  assign restart   = pll_wr && wr_on && (!on || mult_new);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on      <= 1'b0;
      stab    <= '0;
      mult    <= '0;
      stable  <= 1'b0;
      locking <= 1'b0;
      lcnt    <= '0;
    end else begin
      if (pll_wr) begin
        on   <= wr_on;
        stab <= wr_stab;
        mult <= wr_mult;
      end
      if (pll_wr && !wr_on) begin
        stable  <= 1'b0;
        locking <= 1'b0;
      end else if (restart) begin
        stable  <= 1'b0;
        locking <= 1'b1;
        lcnt    <= '0;
      end else if (locking) begin
        if (lcnt == target) begin
          stable  <= 1'b1;
          locking <= 1'b0;
        end else begin
          lcnt <= lcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
  import cdu_pkg::*;
#(
  parameter int          N_OUT      = 5,
  parameter int          STAB_W     = 8,
  parameter int          LOCK_SHIFT = 4,
  parameter int          MULT_W     = 16,
  parameter int          DATA_W     = 32,
  parameter logic [31:0] DEV_RESET  = 32'd4,
  localparam int FIELD_W  = N_OUT * CODE_W,
  localparam int NOW_BIT  = DATA_W - 1,
  localparam int MULT_LSB = DATA_W - MULT_W,
  localparam int BE_W     = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [BE_W-1:0]   wr_be,
  input  logic [DATA_W-1:0] wr_data,
  output logic [N_OUT-1:0]  div_en,
  output logic              pll_on,
  output logic              pll_stable,
  output logic [MULT_W-1:0] pll_mult,
  output logic [DATA_W-1:0] dev_div
);
  logic               ratio_wr, pll_wr, dev_wr;
  logic [FIELD_W-1:0] applied_codes;
  logic               upd_req;
  logic               apply_evt;
  logic               all_wrap;

  assign ratio_wr = wr_en && (wr_sel == SEL_RATIO);
  assign pll_wr   = wr_en && (wr_sel == SEL_PLL);
  assign dev_wr   = wr_en && (wr_sel == SEL_DEV) && (&wr_be);
  assign all_wrap = &div_en;

  cdu_ratio_bank #(.N_OUT(N_OUT)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr    (ratio_wr),
    .ctl_codes (wr_data[FIELD_W-1:0]),
    .ctl_now   (wr_data[NOW_BIT]),
    .apply_evt (apply_evt),
    .boundary  (all_wrap),
    .applied   (applied_codes),
    .req       (upd_req)
  );

  for (genvar g = 0; g < N_OUT; g++) begin : g_lane
    cdu_div_lane u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .code  (applied_codes[g*CODE_W +: CODE_W]),
      .tick  (div_en[g])
    );
  end

  cdu_lock_seq #(
    .STAB_W     (STAB_W),
    .LOCK_SHIFT (LOCK_SHIFT),
    .MULT_W     (MULT_W)
  ) u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .pll_wr    (pll_wr),
    .wr_on     (wr_data[0]),
    .wr_stab   (wr_data[STAB_W:1]),
    .wr_mult   (wr_data[DATA_W-1:MULT_LSB]),
    .on        (pll_on),
    .stable    (pll_stable),
    .mult      (pll_mult),
    .apply_evt (apply_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dev_div <= DEV_RESET[DATA_W-1:0];
    else if (dev_wr) dev_div <= wr_data;
  end
endmodule

// File: rtl/cdu_checker.sv
module cdu_checker #(
  parameter int FIELD_W = 15,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_ratio,
  input logic               wr_pll,
  input logic               wr_dev,
  input logic               wr_on,
  input logic               wr_ce,
  input logic               wr_full,
  input logic               pll_on,
  input logic               pll_stable,
  input logic [DATA_W-1:0]  dev_div,
  input logic [FIELD_W-1:0] applied,
  input logic               all_wrap,
  input logic               upd_req
);
  AST_STABLE_NEEDS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    pll_stable |-> pll_on); // R8

  AST_SWITCH_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (applied != $past(applied)) |-> ($past(all_wrap) && $past(upd_req))); // R9

  AST_OFF_DROPS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pll && !wr_on) |=> (!pll_stable && !pll_on)); // R6

  AST_PARTIAL_DEV_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dev && !wr_full) |=> $stable(dev_div)); // R10

  AST_DEFERRED_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ratio && !wr_ce && !upd_req) |=> $stable(applied)); // R5
endmodule

bind clkdiv_ctrl cdu_checker #(.FIELD_W(FIELD_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_ratio   (wr_en && (wr_sel == 2'd0)),
  .wr_pll     (wr_en && (wr_sel == 2'd1)),
  .wr_dev     (wr_en && (wr_sel == 2'd2)),
  .wr_on      (wr_data[0]),
  .wr_ce      (wr_data[DATA_W-1]),
  .wr_full    (&wr_be),
  .pll_on     (pll_on),
  .pll_stable (pll_stable),
  .dev_div    (dev_div),
  .applied    (applied_codes),
  .all_wrap   (all_wrap),
  .upd_req    (upd_req)
);

// File: tb/sim_clkdiv_ctrl.sv
module sim_clkdiv_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd3;
  logic [3:0]  wr_be = 4'h0;
  logic [31:0] wr_data = '0;
  logic [4:0]  div_en;
  logic        pll_on, pll_stable;
  logic [15:0] pll_mult;
  logic [31:0] dev_div;

  int n_cmp = 0;
  int n_bad = 0;
  string tag = "R1";
  bit done = 1'b0;

  always #4 clk = ~clk;

  clkdiv_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_be(wr_be),
    .wr_data(wr_data), .div_en(div_en), .pll_on(pll_on), .pll_stable(pll_stable),
    .pll_mult(pll_mult), .dev_div(dev_div)
  );

  // ---------------- behavioural reference model ----------------
  int m_ph[5], m_app[5], m_sh[5];
  bit m_req, m_on, m_stable, m_locking;
  int m_lcnt, m_stab, m_mult;
  int m_dev;

  function automatic int period_of(int c);
    case (c)
      0: return 1; 1: return 2; 2: return 3;
      3: return 4; 4: return 6; 5: return 8;
      default: return 1;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 5; i++) begin m_ph[i] = 0; m_app[i] = 0; m_sh[i] = 0; end
      m_req = 0; m_on = 0; m_stable = 0; m_locking = 0;
      m_lcnt = 0; m_stab = 0; m_mult = 0; m_dev = 4;
    end else begin
      bit bw, ev, rs, nw_on;
      int nw_stab, nw_mult;
      bw = 1; ev = 0; rs = 0;
      for (int i = 0; i < 5; i++)
        if (m_ph[i] != period_of(m_app[i]) - 1) bw = 0;
      for (int i = 0; i < 5; i++)
        m_ph[i] = (m_ph[i] + 1) % period_of(m_app[i]);
      nw_on = wr_data[0];
      nw_stab = int'(wr_data[8:1]);
      nw_mult = int'(wr_data[31:16]);
      if (wr_en && wr_sel == 2'd1) begin
        ev = m_on && (!nw_on || nw_mult != m_mult);
        rs = nw_on && (!m_on || nw_mult != m_mult);
      end
      if (wr_en && wr_sel == 2'd1 && !nw_on) begin
        m_stable = 0; m_locking = 0;
      end else if (rs) begin
        m_stable = 0; m_locking = 1; m_lcnt = 0;
      end else if (m_locking) begin
        if (m_lcnt == m_stab * 16) begin m_stable = 1; m_locking = 0; end
        else m_lcnt++;
      end
      if (wr_en && wr_sel == 2'd1) begin
        m_on = nw_on; m_stab = nw_stab; m_mult = nw_mult;
      end
      if (m_req && bw)
        for (int i = 0; i < 5; i++) m_app[i] = m_sh[i];
      m_req = (m_req && !bw) || (wr_en && wr_sel == 2'd0 && wr_data[31]) || ev;
      if (wr_en && wr_sel == 2'd0)
        for (int i = 0; i < 5; i++) m_sh[i] = int'(wr_data[3*i +: 3]);
      if (wr_en && wr_sel == 2'd2 && wr_be == 4'hF) m_dev = int'(wr_data);
    end
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [4:0] e_en;
      for (int i = 0; i < 5; i++) e_en[i] = (m_ph[i] == period_of(m_app[i]) - 1);
      check(div_en == e_en, tag, "div_en", div_en, e_en);
      check(pll_on == m_on, "R6", "pll_on", pll_on, m_on);
      check(pll_stable == m_stable, "R8", "pll_stable", pll_stable, m_stable);
      check(pll_mult == m_mult[15:0], "R7", "pll_mult", pll_mult, m_mult);
      check(dev_div == m_dev, "R10", "dev_div", dev_div, m_dev);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [1:0] sel, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_be = be; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 2'd3; wr_be = 4'h0; wr_data = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] ratio_word(int c0, int c1, int c2, int c3, int c4, bit now);
    logic [31:0] w;
    w = '0;
    w[2:0] = c0[2:0]; w[5:3] = c1[2:0]; w[8:6] = c2[2:0];
    w[11:9] = c3[2:0]; w[14:12] = c4[2:0]; w[31] = now;
    return w;
  endfunction

  function automatic logic [31:0] pll_word(bit on, int stab, int mult);
    return {mult[15:0], 7'd0, stab[7:0], on};
  endfunction

  initial begin
    idle(3);
    rst_n = 1'b1;
    tag = "R1"; idle(6);
    tag = "R2"; wr(2'd0, 4'hF, ratio_word(0, 1, 2, 3, 4, 1)); idle(50);
    tag = "R4"; wr(2'd0, 4'hF, ratio_word(5, 4, 3, 2, 1, 1)); idle(7);
    wr(2'd0, 4'hF, ratio_word(1, 2, 3, 4, 5, 1)); idle(3);
    wr(2'd0, 4'hF, ratio_word(3, 3, 1, 0, 2, 0)); idle(60);
    tag = "R3"; wr(2'd0, 4'hF, ratio_word(6, 7, 5, 6, 7, 1)); idle(40);
    tag = "R5"; wr(2'd0, 4'hF, ratio_word(1, 1, 4, 1, 1, 0)); idle(40);
    tag = "R11"; wr(2'd1, 4'hF, pll_word(1, 2, 16)); idle(45);
    tag = "R7"; wr(2'd1, 4'hF, pll_word(1, 1, 32)); idle(30);
    tag = "R5"; wr(2'd0, 4'hF, ratio_word(5, 3, 2, 4, 0, 0)); idle(20);
    tag = "R6"; wr(2'd1, 4'hF, pll_word(0, 1, 32)); idle(40);
    tag = "R8"; wr(2'd1, 4'hF, pll_word(1, 0, 32)); idle(6);
    wr(2'd1, 4'hF, pll_word(1, 3, 32)); idle(4);
    wr(2'd1, 4'hF, pll_word(0, 3, 32)); idle(2);
    wr(2'd1, 4'hF, pll_word(1, 5, 7)); idle(30);
    wr(2'd1, 4'hF, pll_word(0, 5, 7)); idle(10);
    tag = "R9"; wr(2'd0, 4'hF, ratio_word(4, 5, 2, 1, 3, 1)); idle(2);
    wr(2'd0, 4'hF, ratio_word(2, 2, 2, 2, 2, 0)); idle(50);
    tag = "R10"; wr(2'd2, 4'b0111, 32'h0000_0055); idle(3);
    wr(2'd2, 4'b1110, 32'hABCD_0000); idle(3);
    wr(2'd2, 4'hF, 32'h0000_1234); idle(4);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule